// File: doc/BRIEF.md
# Single-Cycle Register and Immediate Arithmetic Core

This block is a small sequential processor core. It executes one instruction per clock from a narrow instruction subset: register-to-register arithmetic and logic, register copy, immediate load, and a fused immediate add. The fused immediate add puts a 64-bit constant onto a register in one instruction. Without it, the constant first goes into a scratch register and a separate add follows. Every instruction is fetched, decoded and executed, and its result is written back with the program counter advanced, all in the same cycle.

The core presents its program counter on a fetch address output. It takes back a ten-byte window of instruction memory beginning at that address, with byte i on bits [8i+7:8i]. The core holds fifteen 64-bit general registers and three condition flags: zero, sign and overflow. A debug select input reads any register combinationally. A status output reports whether the core is running, has halted, or has stopped on an illegal instruction. Once the core leaves the running state, all of its state stays frozen until reset.

Top module: `seq_core`

## Requirements
- R1: While reset is asserted and right after it is released, the PC is 0, all fifteen registers read 0, the flags are zero=1, sign=0, overflow=0, and the status is 0 (running).
- R2: Byte 0 of an instruction carries the opcode in bits [7:4] and the function code in bits [3:0]. Byte 1 carries the first register specifier in bits [7:4] and the second (destination) register specifier in bits [3:0]. An arithmetic instruction (opcode 0x6) writes R[dst] op R[src] into the destination and advances the PC by 2. Function codes 0, 1, 2 and 3 select add, subtract (dst minus src), AND and XOR.
- R3: An arithmetic instruction sets zero when the result is 0 and sets sign to result bit 63. Overflow is set on add when both operands have the same sign and the result's sign differs. On subtract, overflow is set when the operands' signs differ and the result's sign differs from the destination operand. AND and XOR clear overflow.
- R4: Register copy (byte 0 = 0x20) writes R[src] into the destination, advances the PC by 2 and leaves all three flags unchanged.
- R5: Immediate load (byte 0 = 0x30, first specifier 0xF) writes the 8-byte little-endian constant held in bytes 2 to 9 into the destination, advances the PC by 10 and leaves the flags unchanged.
- R6: Immediate add (byte 0 = 0xC0, first specifier 0xF) writes R[dst] + constant into the destination, sets all three flags exactly as an arithmetic add does, and advances the PC by 10.
- R7: When the destination specifier is 0xF, no register is written. The PC and flags still update as the instruction defines.
- R8: Byte 0 = 0x00 sets the status to 1 (halted). From then on the PC, registers, flags and status stay constant.
- R9: An illegal instruction sets the status to 2 (illegal) without writing any register or flag and without moving the PC. Illegal means any of: an opcode other than 0x0, 0x2, 0x3, 0x6 or 0xC; an arithmetic function code above 3; a nonzero function code on opcodes 0x2, 0x3 or 0xC; or a first specifier other than 0xF on opcodes 0x3 or 0xC. The state then stays frozen.
- R10: An instruction that reads and writes the same register uses the register's value from before the instruction. The next instruction sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_pc | output | 64 | Byte address of the current instruction |
| fetch_bytes | input | 80 | Ten instruction bytes starting at fetch_pc, byte i on bits [8i+7:8i] |
| dbg_reg_sel | input | 4 | Register index for the debug read |
| dbg_reg_data | output | 64 | Value of the selected register (0 for index 15) |
| flag_zero | output | 1 | Zero condition flag |
| flag_sign | output | 1 | Sign condition flag |
| flag_ovf | output | 1 | Overflow condition flag |
| core_status | output | 2 | 0 running, 1 halted, 2 illegal instruction |

## Verification
Register write-back and the flag update land on the same clock edge for arithmetic and immediate-add instructions. In the same cycle, the register being written is also being read as an operand. Back-to-back immediate adds on one register provoke this, and so does an XOR of a register with itself. The outcome is judged by reading the register and the flags after each step and comparing them with values the bench works out from the pre-instruction contents. A copy or an immediate load that follows a flag-setting instruction shows that only the register changes in that cycle.

// File: rtl/seqcore_pkg.sv
package seqcore_pkg;
  localparam int XLEN      = 64;
  localparam int SPEC_W    = 4;
  localparam int IMM_BYTES = XLEN / 8;
  localparam int WIN_BYTES = 2 + IMM_BYTES;

  localparam logic [SPEC_W-1:0] REG_NONE = 4'hF;

  localparam logic [3:0] IC_HALT  = 4'h0;
  localparam logic [3:0] IC_RRMOV = 4'h2;
  localparam logic [3:0] IC_IRMOV = 4'h3;
  localparam logic [3:0] IC_ARITH = 4'h6;
  localparam logic [3:0] IC_IADD  = 4'hC;

  typedef enum logic [1:0] {ST_RUN = 2'd0, ST_HLT = 2'd1, ST_INS = 2'd2} stat_e;
  typedef enum logic [1:0] {FN_ADD = 2'd0, FN_SUB = 2'd1, FN_AND = 2'd2, FN_XOR = 2'd3} alufn_e;

  typedef struct packed {
    logic [XLEN-1:0] res;
    logic            zf;
    logic            sf;
    logic            of;
  } alu_out_t;

  // lhs is the destination-side operand, rhs the source-side operand
  function automatic alu_out_t alu_eval(alufn_e fn, logic [XLEN-1:0] lhs, logic [XLEN-1:0] rhs);
    alu_out_t o;
    o.of = 1'b0;
    unique case (fn)
      FN_ADD: begin
        o.res = lhs + rhs;
        o.of  = (lhs[XLEN-1] == rhs[XLEN-1]) && (o.res[XLEN-1] != lhs[XLEN-1]);
      end
      FN_SUB: begin
        o.res = lhs - rhs;
        o.of  = (lhs[XLEN-1] != rhs[XLEN-1]) && (o.res[XLEN-1] != lhs[XLEN-1]);
      end
      FN_AND:  o.res = lhs & rhs;
      default: o.res = lhs ^ rhs;
    endcase
    o.zf = (o.res == '0);
    o.sf = o.res[XLEN-1];
    return o;
  endfunction
endpackage

// File: rtl/seq_fetch.sv
module seq_fetch
  import seqcore_pkg::*;
(
  input  logic [8*WIN_BYTES-1:0] win_i,
  output logic [SPEC_W-1:0]      src_o,
  output logic [SPEC_W-1:0]      dst_o,
  output logic [XLEN-1:0]        imm_o,
  output logic [3:0]             len_o,
  output alufn_e                 fn_o,
  output logic                   is_arith_o,
  output logic                   is_copy_o,
  output logic                   is_load_o,
  output logic                   is_iadd_o,
  output logic                   is_halt_o,
  output logic                   legal_o
);
  logic [3:0] opc, fcode;

  assign opc   = win_i[7:4];
  assign fcode = win_i[3:0];
  assign src_o = win_i[15:12];
  assign dst_o = win_i[11:8];
  assign imm_o = win_i[8*WIN_BYTES-1:16];

  assign is_arith_o = (opc == IC_ARITH);
  assign is_copy_o  = (opc == IC_RRMOV);
  assign is_load_o  = (opc == IC_IRMOV);
  assign is_iadd_o  = (opc == IC_IADD);
  assign is_halt_o  = (opc == IC_HALT);

  always_comb begin
    legal_o = 1'b0;
    if (is_arith_o)                  legal_o = (fcode[3:2] == 2'b00);
    else if (is_copy_o)              legal_o = (fcode == 4'h0);
    else if (is_load_o || is_iadd_o) legal_o = (fcode == 4'h0) && (src_o == REG_NONE);
  end

  assign len_o = (is_load_o || is_iadd_o) ? 4'(WIN_BYTES) : 4'd2;
  assign fn_o  = is_arith_o ? alufn_e'(fcode[1:0]) : FN_ADD;
endmodule

// File: rtl/seq_regfile.sv
module seq_regfile #(
  parameter int NREGS = 15,
  parameter int W     = 64,
  localparam int AW   = $clog2(NREGS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rsel_a_i,
  input  logic [AW-1:0] rsel_b_i,
  output logic [W-1:0]  rdata_a_o,
  output logic [W-1:0]  rdata_b_o,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] dsel_i,
  output logic [W-1:0]  ddata_o
);
  logic [W-1:0] regs [NREGS];

  function automatic logic [W-1:0] rd(input logic [AW-1:0] idx, input logic [W-1:0] arr [NREGS]);
    return (idx < AW'(NREGS)) ? arr[idx] : '0;
  endfunction

  assign rdata_a_o = rd(rsel_a_i, regs);
  assign rdata_b_o = rd(rsel_b_i, regs);
  assign ddata_o   = rd(dsel_i, regs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we_i && (waddr_i < AW'(NREGS))) begin
      regs[waddr_i] <= wdata_i;
    end
  end

  // R7: a write is never requested for the "no register" specifier
  p_no_dummy_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |-> (waddr_i < AW'(NREGS)));
endmodule

// File: rtl/seq_core.sv
module seq_core
  import seqcore_pkg::*;
#(
  parameter int NREGS = 15
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic [XLEN-1:0]        fetch_pc,
  input  logic [8*WIN_BYTES-1:0] fetch_bytes,
  input  logic [SPEC_W-1:0]      dbg_reg_sel,
  output logic [XLEN-1:0]        dbg_reg_data,
  output logic                   flag_zero,
  output logic                   flag_sign,
  output logic                   flag_ovf,
  output logic [1:0]             core_status
);
  logic [XLEN-1:0] pc_q;
  stat_e           status_q;
  logic            zf_q, sf_q, of_q;

  logic [SPEC_W-1:0] src, dst;
  logic [XLEN-1:0]   imm, val_src, val_dst, lhs, rhs;
  logic [3:0]        len;
  alufn_e            fn;
  logic is_arith, is_copy, is_load, is_iadd, is_halt, legal;
  alu_out_t          alu;

  // named internal events
  logic running, exec, rf_we, cc_we;

  seq_fetch u_fetch (
    .win_i(fetch_bytes), .src_o(src), .dst_o(dst), .imm_o(imm), .len_o(len),
    .fn_o(fn), .is_arith_o(is_arith), .is_copy_o(is_copy), .is_load_o(is_load),
    .is_iadd_o(is_iadd), .is_halt_o(is_halt), .legal_o(legal)
  );

  seq_regfile #(.NREGS(NREGS), .W(XLEN)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .rsel_a_i(src), .rsel_b_i(dst), .rdata_a_o(val_src), .rdata_b_o(val_dst),
    .we_i(rf_we), .waddr_i(dst), .wdata_i(alu.res),
    .dsel_i(dbg_reg_sel), .ddata_o(dbg_reg_data)
  );

  assign running = (status_q == ST_RUN);
  assign exec    = running && legal;
  assign rf_we   = exec && (dst != REG_NONE);
  assign cc_we   = exec && (is_arith || is_iadd);

  // operand routing: moves pass through the adder with a zero left side
  always_comb begin
    lhs = (is_arith || is_iadd) ? val_dst : '0;
    rhs = (is_load  || is_iadd) ? imm     : val_src;
  end

  assign alu = alu_eval(fn, lhs, rhs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      status_q <= ST_RUN;
      zf_q     <= 1'b1;
      sf_q     <= 1'b0;
      of_q     <= 1'b0;
    end else if (running) begin
      if (is_halt)     status_q <= ST_HLT;
      else if (!legal) status_q <= ST_INS;
      else             pc_q     <= pc_q + XLEN'(len);
      if (cc_we) begin
        zf_q <= alu.zf;
        sf_q <= alu.sf;
        of_q <= alu.of;
      end
    end
  end

  assign fetch_pc    = pc_q;
  assign flag_zero   = zf_q;
  assign flag_sign   = sf_q;
  assign flag_ovf    = of_q;
  assign core_status = status_q;

  // R8/R9: once stopped, nothing architectural moves
  p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q != ST_RUN) |=> ($stable(pc_q) && $stable(status_q) && $stable({zf_q, sf_q, of_q})));
  // R2/R4: two-byte instructions step the PC by 2
  p_short_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (is_arith || is_copy)) |=> (pc_q == $past(pc_q) + 64'd2));
  // R6/R5: instructions with a constant step by the full window
  p_long_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (is_load || is_iadd)) |=> (pc_q == $past(pc_q) + XLEN'(WIN_BYTES)));
  // R4/R5: moves keep the flags
  p_move_keeps_cc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running && (is_copy || is_load)) |=> $stable({zf_q, sf_q, of_q}));
  // R3: logic operations clear overflow
  p_logic_clears_of_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_we && (fn == FN_AND || fn == FN_XOR)) |=> !of_q);
  // R9: an illegal encoding never writes a register
  p_illegal_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !legal) |-> !rf_we);
endmodule

// File: tb/seq_core_bench.sv
`timescale 1ns/1ps
module seq_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] fetch_pc;
  logic [79:0] fetch_bytes;
  logic [3:0]  dbg_reg_sel = 4'd0;
  logic [63:0] dbg_reg_data;
  logic        flag_zero, flag_sign, flag_ovf;
  logic [1:0]  core_status;

  logic [7:0] imem [256];
  int wp;
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 10; i++) fetch_bytes[8*i +: 8] = imem[fetch_pc[7:0] + 8'(i)];
  end

  seq_core u_seq_core (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_bytes(fetch_bytes),
    .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(dbg_reg_data),
    .flag_zero(flag_zero), .flag_sign(flag_sign), .flag_ovf(flag_ovf),
    .core_status(core_status)
  );

  localparam logic [3:0] NR = 4'hF;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] idx, output logic [63:0] v);
    dbg_reg_sel = idx;
    #1;
    v = dbg_reg_data;
  endtask

  task automatic chk_reg(input string tag, input logic [3:0] idx, input logic [63:0] exp);
    logic [63:0] v;
    rd(idx, v);
    chk(tag, v, exp);
  endtask

  task automatic chk_cc(input string tag, input logic z, input logic s, input logic o);
    chk(tag, {61'd0, flag_zero, flag_sign, flag_ovf}, {61'd0, z, s, o});
  endtask

  task automatic put_b(input logic [7:0] b);
    imem[wp] = b;
    wp++;
  endtask

  task automatic ins2(input logic [7:0] b0, input logic [3:0] ra, input logic [3:0] rb);
    put_b(b0);
    put_b({ra, rb});
  endtask

  task automatic ins_imm(input logic [7:0] b0, input logic [3:0] rb, input logic [63:0] k);
    ins2(b0, NR, rb);
    for (int i = 0; i < 8; i++) put_b(k[8*i +: 8]);
  endtask

  task automatic new_prog();
    for (int i = 0; i < 256; i++) imem[i] = 8'h00;
    wp = 0;
  endtask

  task automatic restart();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    new_prog();
    rst_n = 1'b0;
    step(1);
    chk("R1 pc in reset", fetch_pc, 64'd0);
    chk("R1 status in reset", {62'd0, core_status}, 64'd0);
    chk_cc("R1 flags in reset", 1'b1, 1'b0, 1'b0);
    for (int r = 0; r < 15; r++) chk_reg("R1 reg in reset", 4'(r), 64'd0);
    chk_reg("R1 index 15 reads 0", 4'hF, 64'd0);
  endtask

  task automatic t_load();
    new_prog();
    ins_imm(8'h30, 4'd2, 64'h1122_3344_5566_7788);
    restart();
    step(1);
    chk_reg("R5 little-endian constant", 4'd2, 64'h1122_3344_5566_7788);
    chk("R5 pc+10", fetch_pc, 64'd10);
    chk_cc("R5 flags untouched", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_arith();
    new_prog();
    ins_imm(8'h30, 4'd0, 64'd5);
    ins_imm(8'h30, 4'd1, 64'd3);
    ins2(8'h61, 4'd0, 4'd1);
    ins2(8'h62, 4'd0, 4'd1);
    ins2(8'h60, 4'd1, 4'd0);
    ins2(8'h63, 4'd1, 4'd1);
    restart();
    step(3);
    chk_reg("R2 sub gives dst-src", 4'd1, 64'hFFFF_FFFF_FFFF_FFFE);
    chk("R2 pc after sub", fetch_pc, 64'd22);
    chk_cc("R3 sub negative flags", 1'b0, 1'b1, 1'b0);
    step(1);
    chk_reg("R2 and result", 4'd1, 64'd4);
    chk_cc("R3 and flags", 1'b0, 1'b0, 1'b0);
    step(1);
    chk_reg("R2 add result", 4'd0, 64'd9);
    chk("R2 pc after add", fetch_pc, 64'd26);
    step(1);
    chk_reg("R10 xor self uses old value", 4'd1, 64'd0);
    chk_cc("R3 zero result flags", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_overflow();
    new_prog();
    ins_imm(8'h30, 4'd3, 64'h7FFF_FFFF_FFFF_FFFF);
    ins_imm(8'hC0, 4'd3, 64'd1);
    ins_imm(8'h30, 4'd4, 64'h8000_0000_0000_0000);
    ins_imm(8'h30, 4'd5, 64'd1);
    ins2(8'h61, 4'd5, 4'd4);
    ins2(8'h63, 4'd5, 4'd4);
    restart();
    step(2);
    chk_reg("R6 iadd wraps", 4'd3, 64'h8000_0000_0000_0000);
    chk_cc("R6 iadd overflow flags", 1'b0, 1'b1, 1'b1);
    chk("R6 pc+10", fetch_pc, 64'd20);
    step(3);
    chk_reg("R2 sub wraps", 4'd4, 64'h7FFF_FFFF_FFFF_FFFF);
    chk_cc("R3 sub overflow", 1'b0, 1'b0, 1'b1);
    step(1);
    chk_reg("R2 xor result", 4'd4, 64'h7FFF_FFFF_FFFF_FFFE);
    chk_cc("R3 xor clears overflow", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_copy();
    new_prog();
    ins_imm(8'h30, 4'd7, 64'd5);
    ins_imm(8'h30, 4'd8, 64'd6);
    ins2(8'h61, 4'd8, 4'd7);
    ins2(8'h20, 4'd7, 4'd9);
    ins_imm(8'h30, 4'd10, 64'd0);
    restart();
    step(4);
    chk_reg("R4 copy value", 4'd9, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R4 pc+2", fetch_pc, 64'd24);
    chk_cc("R4 flags kept", 1'b0, 1'b1, 1'b0);
    step(1);
    chk_reg("R5 zero load", 4'd10, 64'd0);
    chk_cc("R5 zero load keeps flags", 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_iadd_chain();
    new_prog();
    ins_imm(8'h30, 4'd6, 64'd10);
    ins_imm(8'hC0, 4'd6, 64'd5);
    ins_imm(8'hC0, 4'd6, 64'hFFFF_FFFF_FFFF_FFF1);
    ins_imm(8'hC0, 4'd14, 64'd7);
    restart();
    step(2);
    chk_reg("R10 iadd sees load", 4'd6, 64'd15);
    chk_cc("R6 positive flags", 1'b0, 1'b0, 1'b0);
    step(1);
    chk_reg("R10 chained iadd", 4'd6, 64'd0);
    chk_cc("R6 zero flag", 1'b1, 1'b0, 1'b0);
    chk("R6 pc after chain", fetch_pc, 64'd30);
    step(1);
    chk_reg("R6 top register", 4'd14, 64'd7);
  endtask

  task automatic t_no_dest();
    new_prog();
    ins_imm(8'h30, NR, 64'h55);
    restart();
    step(1);
    chk("R7 pc advances", fetch_pc, 64'd10);
    for (int r = 0; r < 15; r++) chk_reg("R7 no register written", 4'(r), 64'd0);
  endtask

  task automatic t_halt();
    new_prog();
    ins_imm(8'h30, 4'd2, 64'd1);
    put_b(8'h00);
    put_b(8'h00);
    ins_imm(8'h30, 4'd2, 64'd2);
    restart();
    step(2);
    chk("R8 status halted", {62'd0, core_status}, 64'd1);
    step(3);
    chk("R8 pc frozen", fetch_pc, 64'd10);
    chk_reg("R8 register frozen", 4'd2, 64'd1);
  endtask

  task automatic t_illegal();
    new_prog();
    ins2(8'h90, 4'd0, 4'd1);
    restart();
    step(2);
    chk("R9 bad opcode status", {62'd0, core_status}, 64'd2);
    chk("R9 bad opcode pc", fetch_pc, 64'd0);

    new_prog();
    ins_imm(8'h30, 4'd1, 64'd4);
    ins2(8'hC0, 4'd0, 4'd1);
    for (int i = 0; i < 8; i++) put_b(8'h01);
    restart();
    step(3);
    chk("R9 iadd bad src status", {62'd0, core_status}, 64'd2);
    chk("R9 iadd bad src pc", fetch_pc, 64'd10);
    chk_reg("R9 no write", 4'd1, 64'd4);
    chk_cc("R9 flags untouched", 1'b1, 1'b0, 1'b0);

    new_prog();
    ins2(8'h64, 4'd0, 4'd1);
    restart();
    step(1);
    chk("R9 bad function status", {62'd0, core_status}, 64'd2);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) imem[i] = 8'h00;
    t_reset();
    t_load();
    t_arith();
    t_overflow();
    t_copy();
    t_iadd_chain();
    t_no_dest();
    t_halt();
    t_illegal();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule